// File: doc/BRIEF.md
# Set-Associative Instruction Cache Controller

This block is a read-only, set-associative instruction cache placed between an instruction fetch port and a memory bus of 32-bit words. The fetch side hands over one request at a time through a valid/ready handshake and gets a single-cycle response pulse carrying the instruction word. A hit is answered from the line storage after a programmable hit latency. A miss picks a victim way from a separate usage-counter replacement unit, then refills the whole line one word at a time. The refill starts with the requested word and wraps around the line, and the response follows after a programmable miss latency.

Fetches marked cache-inhibit, and all fetches while the cache is disabled, go straight to memory as a single word read and leave the cache untouched. A line-invalidate request clears the way of the addressed set whose tag matches. While the cache is disabled, the same request clears every way of that set. A memory error during a refill kills the line being filled, and the fetch returns zero.

Top module: `icache_ctrl`

## Requirements
- R1: After reset every line is invalid, `f_ready` is high, and `r_valid` and `m_req` are low. The first fetch of any address is therefore a miss.
- R2: Address bits [OFF_W-1:2] select the word inside a line (OFF_W = log2 of the line size in bytes). The next log2(SETS) bits select the set, and all bits above them form the tag. Lines of different sets never evict each other.
- R3: While `cache_en` is low, or when `f_inhibit` is high at acceptance, the fetch makes exactly one memory read at its own address. The response is the returned word, or zero if `m_err` is set. Tag and usage state do not change.
- R4: A miss reads the whole line. The first read is the requested word, and the word index then increases by one modulo the words per line, with no word read twice.
- R5: A hit makes no memory read. It returns the stored word, with `r_valid` high in the (hit_lat+2)-th cycle after the accepting clock edge.
- R6: A miss or a bypass answers with `r_valid` high in the (miss_lat+1)-th cycle after the clock edge that takes the last refill word or the error. For a bypass this is the 1st cycle after the edge that takes its only word.
- R7: Each way has a usage counter that runs from 0 to USTATES-1. A hit decrements the counters of the set that are above the hit way's counter. A miss takes the way with the lowest counter (lowest index on a tie) and decrements all non-zero counters. In both cases the accessed way is loaded with USTATES-1.
- R8: If `m_err` comes with a refill word, the refill stops. The response data is zero, and the line's tag is made invalid with its counter cleared, so the next fetch of that line misses.
- R9: An invalidate with `cache_en` high clears only the way of the addressed set whose tag matches. Other ways and other tags keep hitting.
- R10: An invalidate with `cache_en` low clears every way of the addressed set, whatever the tag.
- R11: An invalidate is taken in one idle cycle and has priority over a fetch: `f_ready` is low while `inv_valid` is high, and the fetch is not accepted.
- R12: Each accepted fetch gives exactly one single-cycle `r_valid` pulse. `m_req` and `m_addr` hold steady until `m_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Cache enable; low sends every fetch to memory |
| hit_lat | input | LAT_W | Extra cycles before a hit response |
| miss_lat | input | LAT_W | Extra cycles after a refill before the response |
| f_valid | input | 1 | Fetch request valid |
| f_ready | output | 1 | Controller can take a fetch |
| f_addr | input | ADDR_W | Fetch byte address |
| f_inhibit | input | 1 | Fetch bypasses the cache |
| r_valid | output | 1 | Response pulse |
| r_data | output | 32 | Instruction word of the response |
| inv_valid | input | 1 | Line invalidate request |
| inv_addr | input | ADDR_W | Address whose set (and tag) is invalidated |
| m_req | output | 1 | Memory read request |
| m_addr | output | ADDR_W | Memory read address |
| m_ack | input | 1 | Memory read done |
| m_rdata | input | 32 | Memory read data |
| m_err | input | 1 | Memory read error, valid with m_ack |

## Verification
The bench targets the refill order when the fetch starts mid-line. A design that fills from word 0 would issue the wrong sequence of memory addresses. It also covers a replacement sequence over three tags in one two-way set: a wrong counter update would evict the recently used way and turn an expected hit into a full refill. Refill errors on the critical word and on a later word check that the response is zero and that the line misses again. Invalidates with the cache on and off, on a matching and a non-matching tag, show up as hits that should have been misses or the other way round.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_REFILL,
    ST_RESPOND,
    ST_BYPASS
  } ic_state_e;
endpackage

// File: rtl/icache_store.sv
module icache_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int WORDS = 4,
  parameter int TAG_W = 26,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int WO_W  = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SET_W-1:0]      set_i,
  output logic [WAYS*TAG_W-1:0] tags_o,
  input  logic [WAY_W-1:0]      rd_way_i,
  input  logic [WO_W-1:0]       rd_word_i,
  output logic [31:0]           rd_data_o,
  input  logic                  tag_we_i,
  input  logic [WAY_W-1:0]      tag_way_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic [WAYS-1:0]       clr_mask_i,
  input  logic                  data_we_i,
  input  logic [WAY_W-1:0]      data_way_i,
  input  logic [WO_W-1:0]       data_word_i,
  input  logic [31:0]           data_i
);
  // Invalid tag is all ones; zero is a legal tag.
  logic [SETS*WAYS-1:0][TAG_W-1:0]    tag_q;
  logic [SETS*WAYS*WORDS-1:0][31:0]   dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '1;
      dat_q <= '0;
    end else begin
      if (tag_we_i) tag_q[{set_i, tag_way_i}] <= tag_i;
      for (int w = 0; w < WAYS; w++) begin
        if (clr_mask_i[w]) tag_q[{set_i, WAY_W'(w)}] <= '1;
      end
      if (data_we_i) dat_q[{set_i, data_way_i, data_word_i}] <= data_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_tag_out
    assign tags_o[w*TAG_W +: TAG_W] = tag_q[{set_i, WAY_W'(w)}];
  end

  assign rd_data_o = dat_q[{set_i, rd_way_i, rd_word_i}];
endmodule

// File: rtl/icache_match.sv
module icache_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 26,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]      lk_tag_i,
  output logic [WAYS-1:0]       match_o,
  output logic                  hit_o,
  output logic [WAY_W-1:0]      hit_way_o
);
  // Parallel compare of every way; an all-ones tag never matches.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = (tags_i[w*TAG_W +: TAG_W] == lk_tag_i) &&
                        !(&tags_i[w*TAG_W +: TAG_W]);
  end

  assign hit_o = |match_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) hit_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/icache_replace.sv
module icache_replace #(
  parameter int SETS    = 4,
  parameter int WAYS    = 2,
  parameter int USTATES = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int UW     = $clog2(USTATES),
  localparam int RELOAD = USTATES - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             miss_i,
  input  logic [WAYS-1:0]  clr_mask_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [SETS*WAYS-1:0][UW-1:0] cnt_q;
  logic [UW-1:0]                best;

  // Lowest counter wins, lowest index on a tie.
  always_comb begin
    victim_o = '0;
    best     = cnt_q[{set_i, WAY_W'(0)}];
    for (int w = 1; w < WAYS; w++) begin
      if (cnt_q[{set_i, WAY_W'(w)}] < best) begin
        best     = cnt_q[{set_i, WAY_W'(w)}];
        victim_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      if (hit_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (cnt_q[{set_i, WAY_W'(w)}] > cnt_q[{set_i, hit_way_i}])
            cnt_q[{set_i, WAY_W'(w)}] <= cnt_q[{set_i, WAY_W'(w)}] - 1'b1;
        end
        cnt_q[{set_i, hit_way_i}] <= UW'(RELOAD);
      end
      if (miss_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (cnt_q[{set_i, WAY_W'(w)}] != '0)
            cnt_q[{set_i, WAY_W'(w)}] <= cnt_q[{set_i, WAY_W'(w)}] - 1'b1;
        end
        cnt_q[{set_i, victim_o}] <= UW'(RELOAD);
      end
      for (int w = 0; w < WAYS; w++) begin
        if (clr_mask_i[w]) cnt_q[{set_i, WAY_W'(w)}] <= '0;
      end
    end
  end

  AST_VICTIM_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> cnt_q[$past({set_i, victim_o})] == UW'(RELOAD)); // R7
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_i && miss_i)); // R7
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int USTATES    = 4,
  parameter int LAT_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic [LAT_W-1:0]  hit_lat,
  input  logic [LAT_W-1:0]  miss_lat,
  input  logic              f_valid,
  output logic              f_ready,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic              f_inhibit,
  output logic              r_valid,
  output logic [31:0]       r_data,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              m_req,
  output logic [ADDR_W-1:0] m_addr,
  input  logic              m_ack,
  input  logic [31:0]       m_rdata,
  input  logic              m_err
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int WO_W  = $clog2(WORDS);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  // ---- address arithmetic ----
  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WO_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[2 +: WO_W];
  endfunction
  function automatic logic [WO_W-1:0] wrap_add(input logic [WO_W-1:0] base,
                                                input logic [WO_W-1:0] step);
    return base + step;
  endfunction

  // ---- state ----
  ic_state_e         st_q;
  logic [ADDR_W-1:0] req_q;
  logic [WAY_W-1:0]  vic_q;
  logic [WO_W-1:0]   wcnt_q;
  logic [LAT_W-1:0]  lat_q;
  logic [31:0]       resp_q;
  logic              err_q;

  // ---- lookup path ----
  logic [SET_W-1:0]      cur_set;
  logic [TAG_W-1:0]      lk_tag;
  logic [WAYS*TAG_W-1:0] tags_flat;
  logic [WAYS-1:0]       match_mask;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way;
  logic [WAY_W-1:0]      victim;
  logic [31:0]           rd_data;
  logic [WO_W-1:0]       cur_word;

  assign cur_set  = (st_q == ST_IDLE) ? set_of(inv_addr) : set_of(req_q);
  assign lk_tag   = (st_q == ST_IDLE) ? tag_of(inv_addr) : tag_of(req_q);
  assign cur_word = wrap_add(word_of(req_q), wcnt_q);

  // ---- named internal events ----
  logic ev_accept, ev_inv, ev_hit, ev_miss;
  logic ev_fill_ack, ev_fill_err, ev_fill_last, ev_byp_ack;
  logic [WAYS-1:0] inv_mask, clr_mask;
  logic tag_we, data_we;

  assign ev_inv       = (st_q == ST_IDLE) && inv_valid;
  assign ev_accept    = (st_q == ST_IDLE) && !inv_valid && f_valid;
  assign ev_hit       = (st_q == ST_LOOKUP) && hit;
  assign ev_miss      = (st_q == ST_LOOKUP) && !hit;
  assign ev_fill_ack  = (st_q == ST_REFILL) && m_ack;
  assign ev_fill_err  = ev_fill_ack && m_err;
  assign ev_fill_last = ev_fill_ack && (wcnt_q == WO_W'(WORDS - 1));
  assign ev_byp_ack   = (st_q == ST_BYPASS) && m_ack;

  assign inv_mask = cache_en ? match_mask : '1;
  assign clr_mask = ev_inv      ? inv_mask :
                    ev_fill_err ? (WAYS'(1) << vic_q) : '0;
  assign tag_we   = ev_miss;
  assign data_we  = ev_fill_ack && !m_err;

  icache_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (cur_set),
    .tags_o     (tags_flat),
    .rd_way_i   (hit_way),
    .rd_word_i  (word_of(req_q)),
    .rd_data_o  (rd_data),
    .tag_we_i   (tag_we),
    .tag_way_i  (victim),
    .tag_i      (lk_tag),
    .clr_mask_i (clr_mask),
    .data_we_i  (data_we),
    .data_way_i (vic_q),
    .data_word_i(cur_word),
    .data_i     (m_rdata)
  );

  icache_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i   (tags_flat),
    .lk_tag_i (lk_tag),
    .match_o  (match_mask),
    .hit_o    (hit),
    .hit_way_o(hit_way)
  );

  icache_replace #(.SETS(SETS), .WAYS(WAYS), .USTATES(USTATES)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (cur_set),
    .hit_i     (ev_hit),
    .hit_way_i (hit_way),
    .miss_i    (ev_miss),
    .clr_mask_i(clr_mask),
    .victim_o  (victim)
  );

  // ---- controller ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= '0;
      vic_q  <= '0;
      wcnt_q <= '0;
      lat_q  <= '0;
      resp_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (ev_accept) begin
            req_q <= f_addr;
            err_q <= 1'b0;
            st_q  <= (!cache_en || f_inhibit) ? ST_BYPASS : ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            resp_q <= rd_data;
            lat_q  <= hit_lat;
            st_q   <= ST_RESPOND;
          end else begin
            vic_q  <= victim;
            wcnt_q <= '0;
            st_q   <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (ev_fill_err) begin
            resp_q <= '0;
            err_q  <= 1'b1;
            lat_q  <= miss_lat;
            st_q   <= ST_RESPOND;
          end else if (ev_fill_ack) begin
            if (wcnt_q == '0) resp_q <= m_rdata;
            wcnt_q <= wcnt_q + 1'b1;
            if (ev_fill_last) begin
              lat_q <= miss_lat;
              st_q  <= ST_RESPOND;
            end
          end
        end
        ST_BYPASS: begin
          if (ev_byp_ack) begin
            resp_q <= m_err ? 32'h0 : m_rdata;
            err_q  <= m_err;
            lat_q  <= '0;
            st_q   <= ST_RESPOND;
          end
        end
        ST_RESPOND: begin
          if (lat_q == '0) st_q <= ST_IDLE;
          else             lat_q <= lat_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign f_ready = (st_q == ST_IDLE) && !inv_valid;
  assign r_valid = (st_q == ST_RESPOND) && (lat_q == '0);
  assign r_data  = resp_q;
  assign m_req   = (st_q == ST_REFILL) || (st_q == ST_BYPASS);
  assign m_addr  = (st_q == ST_BYPASS) ? req_q
                 : {req_q[ADDR_W-1:OFF_W], cur_word, 2'b00};

  // ---- assertions ----
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr))); // R12
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |=> (!r_valid && st_q == ST_IDLE)); // R12
  AST_WRAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fill_ack && !m_err && !ev_fill_last) |=>
      (m_addr[2 +: WO_W] == $past(m_addr[2 +: WO_W]) + 1'b1)); // R4
  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BYPASS) |-> (!tag_we && !data_we && !ev_hit && !ev_miss)); // R3
  AST_HIT_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> !m_req); // R5
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && err_q) |-> (r_data == 32'h0)); // R8
  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOOKUP || ev_inv) |-> $onehot0(match_mask)); // R9
  AST_INV_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv |=> (st_q == ST_IDLE)); // R11
endmodule

// File: tb/tb_icache_ctrl.sv
module tb_icache_ctrl;
  localparam int NSETS = 4;
  localparam int NWAYS = 2;
  localparam int NUST  = 4;

  logic        clk, rst_n, cache_en;
  logic [3:0]  hit_lat, miss_lat;
  logic        f_valid, f_ready, f_inhibit, r_valid;
  logic [31:0] f_addr, r_data;
  logic        inv_valid;
  logic [31:0] inv_addr;
  logic        m_req, m_ack, m_err;
  logic [31:0] m_addr, m_rdata;

  icache_ctrl #(.ADDR_W(32), .LINE_BYTES(16), .SETS(NSETS), .WAYS(NWAYS),
                .USTATES(NUST), .LAT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .hit_lat(hit_lat),
    .miss_lat(miss_lat), .f_valid(f_valid), .f_ready(f_ready), .f_addr(f_addr),
    .f_inhibit(f_inhibit), .r_valid(r_valid), .r_data(r_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .m_req(m_req), .m_addr(m_addr),
    .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // ---- memory model ----
  bit          err_arm = 0;
  logic [31:0] err_addr = '0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_1234;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 1'b0; m_err <= 1'b0; m_rdata <= '0;
    end else begin
      m_ack <= m_req && !m_ack;
      if (m_req && !m_ack) begin
        m_rdata <= memf(m_addr);
        m_err   <= err_arm && ({m_addr[31:2], 2'b00} == err_addr);
      end
    end
  end

  // ---- port monitor ----
  logic [31:0] ack_log[$];
  time         last_ack_t;
  int          rv_pulses = 0;

  always @(negedge clk) begin
    if (m_ack) begin
      ack_log.push_back(m_addr);
      last_ack_t = $time;
    end
    if (r_valid) rv_pulses++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---- behavioural reference model ----
  int mtag[NSETS][NWAYS];
  int mcnt[NSETS][NWAYS];

  task automatic model_reset();
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin
        mtag[s][w] = -1; mcnt[s][w] = 0;
      end
  endtask

  task automatic fetch(input logic [31:0] a, input bit inh, input string req);
    int set = int'((a >> 4) & 32'd3);
    int tg  = int'(a >> 6);
    int w0  = int'((a >> 2) & 32'd3);
    int hw  = -1;
    int kind;        // 0 hit, 1 miss, 2 bypass
    int exp_acks;
    int exp_lat;
    logic [31:0] exp_data;
    logic [31:0] exp_seq[$];
    time t0, tr;
    int n;
    int rv0;
    bit seq_ok;

    exp_data = memf(a);
    if (!cache_en || inh) begin
      kind = 2; exp_acks = 1; exp_lat = 1;
      exp_seq.push_back({a[31:2], 2'b00});
      if (err_arm && {a[31:2], 2'b00} == err_addr) exp_data = 0;
    end else begin
      for (int w = 0; w < NWAYS; w++) if (hw < 0 && mtag[set][w] == tg) hw = w;
      if (hw >= 0) begin
        kind = 0; exp_acks = 0; exp_lat = int'(hit_lat) + 1;
        for (int w = 0; w < NWAYS; w++)
          if (mcnt[set][w] > mcnt[set][hw]) mcnt[set][w]--;
        mcnt[set][hw] = NUST - 1;
      end else begin
        int v = 0;
        kind = 1; exp_lat = int'(miss_lat) + 1;
        for (int w = 1; w < NWAYS; w++) if (mcnt[set][w] < mcnt[set][v]) v = w;
        for (int w = 0; w < NWAYS; w++) if (mcnt[set][w] != 0) mcnt[set][w]--;
        mtag[set][v] = tg; mcnt[set][v] = NUST - 1;
        exp_acks = 4;
        for (int i = 0; i < 4; i++) begin
          logic [31:0] wa = {a[31:4], 4'h0} | (32'((w0 + i) % 4) << 2);
          if (exp_acks == 4) exp_seq.push_back(wa);
          if (exp_acks == 4 && err_arm && wa == err_addr) begin
            exp_acks = i + 1; exp_data = 0;
            mtag[set][v] = -1; mcnt[set][v] = 0;
          end
        end
      end
    end

    ack_log.delete();
    rv0 = rv_pulses;
    @(negedge clk);
    f_valid = 1'b1; f_addr = a; f_inhibit = inh;
    n = 0;
    while (!f_ready && n < 500) begin @(negedge clk); n++; end
    @(negedge clk);
    f_valid = 1'b0; f_inhibit = 1'b0;
    t0 = $time;
    n = 0;
    while (!r_valid && n < 1000) begin @(negedge clk); n++; end
    tr = $time;
    chk(n < 1000, {req, " response arrives"}, 32'(n), 0);
    chk(r_data == exp_data, {req, " data"}, r_data, exp_data);
    @(negedge clk);
    @(negedge clk);
    chk(ack_log.size() == exp_acks, {req, " memory reads"},
        32'(ack_log.size()), 32'(exp_acks));
    seq_ok = (ack_log.size() == exp_seq.size());
    if (seq_ok) foreach (exp_seq[i]) if (ack_log[i] != exp_seq[i]) seq_ok = 0;
    if (kind != 0)
      chk(seq_ok, {req, " R4 read address order"},
          ack_log.size() > 0 ? ack_log[0] : 32'hFFFF_FFFF, exp_seq[0]);
    if (kind == 0)
      chk(int'((tr - t0) / 10) == exp_lat, {req, " R5 hit latency"},
          32'((tr - t0) / 10), 32'(exp_lat));
    else
      chk(int'((tr - last_ack_t) / 10) == exp_lat, {req, " R6 latency"},
          32'((tr - last_ack_t) / 10), 32'(exp_lat));
    chk(rv_pulses - rv0 == 1, {req, " R12 one pulse"}, 32'(rv_pulses - rv0), 1);
  endtask

  task automatic invalidate(input logic [31:0] a, input string req);
    int set = int'((a >> 4) & 32'd3);
    int tg  = int'(a >> 6);
    int rv0 = rv_pulses;
    for (int w = 0; w < NWAYS; w++)
      if (!cache_en || mtag[set][w] == tg) begin
        mtag[set][w] = -1; mcnt[set][w] = 0;
      end
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    f_valid = 1'b1; f_addr = 32'h0000_0F00;
    #1;
    chk(f_ready == 1'b0, {req, " R11 f_ready low during invalidate"}, 32'(f_ready), 0);
    @(negedge clk);
    inv_valid = 1'b0; f_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(m_req == 1'b0 && rv_pulses == rv0, {req, " R11 fetch not taken"},
        32'(m_req), 0);
  endtask

  initial begin
    rst_n = 0; cache_en = 1; hit_lat = 4'd2; miss_lat = 4'd3;
    f_valid = 0; f_addr = 0; f_inhibit = 0; inv_valid = 0; inv_addr = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(f_ready == 1 && r_valid == 0 && m_req == 0, "R1 reset outputs",
        {29'b0, f_ready, r_valid, m_req}, 32'h4);

    fetch(32'h0000_0100, 0, "R1 first fetch misses");
    fetch(32'h0000_0108, 0, "R5 hit other word");
    fetch(32'h0002_0034, 0, "R4 mid-line wrap refill set3");
    fetch(32'h0000_1104, 0, "R2 same set second tag");
    fetch(32'h0000_010C, 0, "R5 hit way0");
    fetch(32'h0000_2100, 0, "R7 third tag evicts older");
    fetch(32'h0000_0100, 0, "R7 recent way kept");
    fetch(32'h0000_1100, 0, "R7 evicted line misses");
    fetch(32'h0002_0038, 0, "R2 other set untouched");

    fetch(32'h0000_3104, 1, "R3 inhibit bypass");
    fetch(32'h0000_1108, 0, "R3 state unchanged after inhibit");
    cache_en = 0;
    fetch(32'h0000_1100, 0, "R3 disabled bypass");
    cache_en = 1;
    fetch(32'h0000_1100, 0, "R3 line still cached");

    invalidate(32'h0000_7100, "R9 non-matching tag");
    fetch(32'h0000_1100, 0, "R9 line survives");
    invalidate(32'h0000_1100, "R9 matching tag");
    fetch(32'h0000_0104, 0, "R9 other way hits");
    fetch(32'h0000_1100, 0, "R9 cleared line misses");
    cache_en = 0;
    invalidate(32'h0000_9900, "R10 disabled clears set");
    cache_en = 1;
    fetch(32'h0000_1100, 0, "R10 way refilled");
    fetch(32'h0000_0100, 0, "R10 other way refilled");
    fetch(32'h0002_0030, 0, "R10 other set kept");

    err_arm = 1; err_addr = 32'h0000_5048;
    fetch(32'h0000_5044, 0, "R8 error on later word");
    err_arm = 0;
    fetch(32'h0000_5044, 0, "R8 killed line misses again");
    err_arm = 1; err_addr = 32'h0000_5208;
    fetch(32'h0000_5208, 0, "R8 error on critical word");
    fetch(32'h0000_5208, 1, "R3 bypass error returns zero");
    err_arm = 0;

    hit_lat = 4'd0; miss_lat = 4'd0;
    fetch(32'h0000_6030, 0, "R6 zero miss latency");
    fetch(32'h0000_603C, 0, "R5 zero hit latency");
    hit_lat = 4'd7; miss_lat = 4'd5;
    fetch(32'h0000_603C, 0, "R5 long hit latency");
    fetch(32'h0000_7A3C, 0, "R6 long miss latency wrap");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule